// File: doc/BRIEF.md
# Line Activity Auto-Powerdown Controller

This block chooses the power mode of a multi-channel serial line interface. It watches every transmit-side and receive-side logic input for transitions, and it reads two control levels. One is an active-low force-off control and the other is an active-high force-on control. From these it settles on one of four modes: active, waking, automatic powerdown or manual powerdown. In each mode it drives a separate enable for the supply pump, the line drivers, the standard receiver outputs and the monitor receiver. It also drives a ready flag that tracks a supply-good report.

Every input passes through a two-flop synchronizer. A line transition reloads an inactivity counter. When that counter runs out, a timed-out flag is set and stays set until a fresh line transition arrives or force-on is seen high. The inactivity period and the wake-up settle period are parameters in clock cycles. The defaults correspond to 30 s and 100 µs at 100 MHz, and a bench can shrink them.

Top module: `line_pwr_ctrl`

## Requirements
- R1: After reset the block is active: pump, driver, receiver and monitor enables are all 1, and ready is 0 until the synchronized supply-good level is seen high.
- R2: With force-off high, force-on low and no line transition, pump and driver enables fall on the (IDLE_CYCLES+1)th rising edge after reset. After a line input change they fall on the (IDLE_CYCLES+4)th edge, counting the first edge that samples the change. The receiver and monitor enables stay 1.
- R3: A transition on any single transmit or receive input restarts the full inactivity period.
- R4: Once the timeout is reached, automatic powerdown persists for any length of time until a line transition or a high force-on level is seen.
- R5: A waking event turns the pump on 4 edges after the event is first sampled, keeping the driver enable 0. The driver enable rises WAKE_CYCLES edges after the pump turns on.
- R6: While force-on is high no automatic powerdown occurs, and a rising force-on wakes an idle block. After force-on falls, the block stays active for a full inactivity period: it powers down on the (IDLE_CYCLES+3)th edge counting the first edge that samples the fall.
- R7: A low force-off gives manual powerdown 3 edges after it is first sampled, whatever the force-on level and the line activity. If force-on is high when force-off is released, the block wakes immediately.
- R8: The standard receiver enable is 0 only in manual powerdown. The monitor enable is 1 in every mode.
- R9: Ready falls on the same edge as the pump enable. It rises during power-up only after the synchronized supply-good level is 1, which is 3 edges after supply-good is first sampled high.
- R10: Releasing force-off while force-on is low and the lines are quiet leaves the block in automatic powerdown, because manual powerdown sets the timeout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_lines | input | N_TX | Transmit-side logic inputs, monitored for transitions |
| rx_lines | input | N_RX | Receive-side logic inputs, monitored for transitions |
| force_off_n | input | 1 | Low forces manual powerdown |
| force_on | input | 1 | High disables automatic powerdown |
| supply_good | input | 1 | Negative supply has reached its threshold |
| pump_en | output | 1 | Supply pump enable |
| tx_drv_en | output | 1 | Line driver output enable (0 = high impedance) |
| rx_out_en | output | 1 | Standard receiver output enable |
| mon_rx_en | output | 1 | Monitor receiver enable |
| ready | output | 1 | Ready-to-transmit flag |

## Verification
The bench aims at the edges of the inactivity window: the last cycle before timeout and the first cycle after it, both after reset and after a restarting transition. A counter that is off by one, or that ignores some inputs, would move or lose that edge. It also checks that the timed-out state survives a long idle stretch and a manual-powerdown release with force-on low. A timer that cleared on its own would wrongly power up there. Other checks cover force-on holding the block up for a full period after its fall, and force-off overriding force-on and line activity. These catch a wrong priority, which would leave the drivers or the standard receivers enabled. A final group checks that ready stays low through waking until supply-good is seen.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_WAKING = 2'd1,
    MODE_AUTO_DN = 2'd2,
    MODE_MAN_DN = 2'd3
  } lpc_mode_e;

  // pump runs while powering up and while active
  function automatic logic mode_pump_on(lpc_mode_e m);
    return (m == MODE_ACTIVE) || (m == MODE_WAKING);
  endfunction

  // drivers only once settled
  function automatic logic mode_drv_on(lpc_mode_e m);
    return m == MODE_ACTIVE;
  endfunction

  // standard receivers are cut only by the manual control
  function automatic logic mode_rxo_on(lpc_mode_e m);
    return m != MODE_MAN_DN;
  endfunction

  function automatic logic mode_is_down(lpc_mode_e m);
    return (m == MODE_AUTO_DN) || (m == MODE_MAN_DN);
  endfunction

endpackage

// File: rtl/lpc_sync_bank.sv
module lpc_sync_bank #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;
  logic [W-1:0] stg2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1[i] <= RST_VAL[i];
        stg2[i] <= RST_VAL[i];
      end else begin
        stg1[i] <= d[i];
        stg2[i] <= stg1[i];
      end
    end
  end

  assign q = stg2;
endmodule

// File: rtl/lpc_edge_det.sv
module lpc_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic         any_chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign any_chg = |(lvl ^ prev);
endmodule

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 100,
  localparam int CW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,     // line activity or force-on
  input  logic hold_set,  // manual powerdown sets the timeout state
  output logic timed_out
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= CW'(IDLE_CYCLES);
      timed_out <= 1'b0;
    end else if (clear) begin
      cnt       <= CW'(IDLE_CYCLES);
      timed_out <= 1'b0;
    end else if (hold_set) begin
      cnt       <= '0;
      timed_out <= 1'b1;
    end else if (cnt == CW'(1)) begin
      cnt       <= '0;
      timed_out <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/lpc_mode_ctrl.sv
module lpc_mode_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 16,
  localparam int WW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      manual,
  input  logic      timed_out,
  input  logic      supply_ok,
  output lpc_mode_e mode,
  output logic      ready
);
  lpc_mode_e     mode_n;
  logic [WW-1:0] wcnt, wcnt_n;
  logic          ready_n;

  always_comb begin
    mode_n = mode;
    wcnt_n = wcnt;
    if (manual) begin
      mode_n = MODE_MAN_DN;
    end else if (timed_out) begin
      mode_n = MODE_AUTO_DN;
    end else begin
      unique case (mode)
        MODE_MAN_DN, MODE_AUTO_DN: begin
          mode_n = MODE_WAKING;
          wcnt_n = WW'(WAKE_CYCLES - 1);
        end
        MODE_WAKING: begin
          if (wcnt == '0) mode_n = MODE_ACTIVE;
          else            wcnt_n = wcnt - WW'(1);
        end
        default: mode_n = MODE_ACTIVE;
      endcase
    end
    // ready tracks the next mode so it drops with the pump
    ready_n = mode_pump_on(mode_n) && (ready || supply_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= MODE_ACTIVE;
      wcnt  <= '0;
      ready <= 1'b0;
    end else begin
      mode  <= mode_n;
      wcnt  <= wcnt_n;
      ready <= ready_n;
    end
  end
endmodule

// File: rtl/line_pwr_ctrl.sv
module line_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter int N_TX = 3,
  parameter int N_RX = 5,
  parameter int unsigned IDLE_CYCLES = 32'd3_000_000_000,
  parameter int unsigned WAKE_CYCLES = 10_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_TX-1:0] tx_lines,
  input  logic [N_RX-1:0] rx_lines,
  input  logic            force_off_n,
  input  logic            force_on,
  input  logic            supply_good,
  output logic            pump_en,
  output logic            tx_drv_en,
  output logic            rx_out_en,
  output logic            mon_rx_en,
  output logic            ready
);
  localparam int NL = N_TX + N_RX;

  logic [NL-1:0] line_lvl;
  logic [2:0]    ctl_lvl;
  logic          foff_lvl, fon_lvl, sg_lvl;
  logic          line_edge, timer_clear, timed_out;
  lpc_mode_e     mode;

  lpc_sync_bank #(.W(NL), .RST_VAL('0)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d({tx_lines, rx_lines}), .q(line_lvl)
  );

  // bit 0 force_off_n (idles high), bit 1 force_on, bit 2 supply_good
  lpc_sync_bank #(.W(3), .RST_VAL(3'b001)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({supply_good, force_on, force_off_n}), .q(ctl_lvl)
  );

  assign foff_lvl = ctl_lvl[0];
  assign fon_lvl  = ctl_lvl[1];
  assign sg_lvl   = ctl_lvl[2];

  lpc_edge_det #(.W(NL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .any_chg(line_edge)
  );

  assign timer_clear = line_edge | fon_lvl;

  lpc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .hold_set(~foff_lvl),
    .timed_out(timed_out)
  );

  lpc_mode_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_mode (
    .clk(clk), .rst_n(rst_n), .manual(~foff_lvl), .timed_out(timed_out),
    .supply_ok(sg_lvl), .mode(mode), .ready(ready)
  );

  assign pump_en   = mode_pump_on(mode);
  assign tx_drv_en = mode_drv_on(mode);
  assign rx_out_en = mode_rxo_on(mode);
  assign mon_rx_en = 1'b1;
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic foff_lvl,
  input logic fon_lvl,
  input logic timer_clear,
  input logic timed_out,
  input logic pump_en,
  input logic tx_drv_en,
  input logic rx_out_en,
  input logic ready
);
  assert_manual_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !foff_lvl |=> (!pump_en && !tx_drv_en && !rx_out_en));

  assert_tx_needs_pump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drv_en |-> pump_en);

  assert_tx_wake_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_drv_en) |-> $past(pump_en));

  assert_ready_low_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> !ready);

  assert_timer_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !timer_clear) |=> timed_out);

  assert_force_on_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fon_lvl |=> !timed_out);

  assert_rx_off_manual_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_out_en) |-> $past(!foff_lvl));
endmodule

bind line_pwr_ctrl lpc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .foff_lvl(foff_lvl), .fon_lvl(fon_lvl),
  .timer_clear(timer_clear), .timed_out(timed_out), .pump_en(pump_en),
  .tx_drv_en(tx_drv_en), .rx_out_en(rx_out_en), .ready(ready)
);

// File: tb/line_pwr_ctrl_bench.sv
module line_pwr_ctrl_bench;
  localparam int N_TX = 3;
  localparam int N_RX = 5;
  localparam int IDLE = 40;
  localparam int WAKE = 8;

  // packed outputs {pump, tx, rx, mon, ready}
  localparam logic [4:0] UP      = 5'b11111;
  localparam logic [4:0] UP_NR   = 5'b11110;
  localparam logic [4:0] WAKE_NR = 5'b10110;
  localparam logic [4:0] WAKE_R  = 5'b10111;
  localparam logic [4:0] AUTO    = 5'b00110;
  localparam logic [4:0] MAN     = 5'b00010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_TX-1:0] tx_lines = '0;
  logic [N_RX-1:0] rx_lines = '0;
  logic force_off_n = 1'b1;
  logic force_on = 1'b0;
  logic supply_good = 1'b1;
  logic pump_en, tx_drv_en, rx_out_en, mon_rx_en, ready;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [4:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  line_pwr_ctrl #(.N_TX(N_TX), .N_RX(N_RX), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE))
  u_line_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_lines(tx_lines), .rx_lines(rx_lines),
    .force_off_n(force_off_n), .force_on(force_on), .supply_good(supply_good),
    .pump_en(pump_en), .tx_drv_en(tx_drv_en), .rx_out_en(rx_out_en),
    .mon_rx_en(mon_rx_en), .ready(ready)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: compare outputs at the negedge after edge number `at`
  always @(negedge clk) begin
    while (rst_n && sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t e;
      logic [4:0] got;
      e = sb_q.pop_front();
      got = {pump_en, tx_drv_en, rx_out_en, mon_rx_en, ready};
      n_checks++;
      if (got !== e.val) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got %b expected %b", e.tag, cyc, got, e.val);
      end
    end
  end

  task automatic expect_at(input int c, input logic [4:0] v, input string tag);
    exp_t e;
    e.at = c; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R9 ready after supply-good sync
    expect_at(0, UP_NR, "R1");
    expect_at(2, UP_NR, "R9");
    expect_at(3, UP, "R9");
    // R2 timeout from reset
    expect_at(IDLE, UP, "R2");
    expect_at(IDLE + 1, AUTO, "R2");
    expect_at(IDLE + 21, AUTO, "R4");
    wait_cyc(42); supply_good = 1'b0;
    // R5 wake by a receive input
    expect_at(73, AUTO, "R5");
    expect_at(74, WAKE_NR, "R5");
    expect_at(77, WAKE_NR, "R9");
    expect_at(78, WAKE_R, "R9");
    expect_at(81, WAKE_R, "R5");
    expect_at(82, UP, "R5");
    // R3 transmit activity restarts the period
    expect_at(114, UP, "R3");
    expect_at(143, UP, "R3");
    expect_at(144, AUTO, "R3");
    wait_cyc(70); rx_lines[2] = 1'b1;
    wait_cyc(75); supply_good = 1'b1;
    wait_cyc(100); tx_lines[0] = 1'b1;
    // R6 force-on wakes and holds
    expect_at(163, AUTO, "R6");
    expect_at(164, WAKE_R, "R6");
    expect_at(172, UP, "R6");
    expect_at(300, UP, "R6");
    expect_at(342, UP, "R6");
    expect_at(343, AUTO, "R6");
    wait_cyc(160); force_on = 1'b1;
    wait_cyc(300); force_on = 1'b0;
    expect_at(362, UP, "R5");
    // R7 manual powerdown overrides force-on and activity, R8 receivers off
    expect_at(372, UP, "R7");
    expect_at(373, MAN, "R8");
    expect_at(390, MAN, "R7");
    expect_at(402, MAN, "R7");
    // R10 release with force-on low stays in automatic powerdown
    expect_at(403, AUTO, "R10");
    expect_at(450, AUTO, "R10");
    expect_at(467, UP, "R5");
    wait_cyc(350); rx_lines[2] = 1'b0;
    wait_cyc(370); force_off_n = 1'b0;
    wait_cyc(380); force_on = 1'b1;
    wait_cyc(385); tx_lines[1] = 1'b1;
    wait_cyc(392); force_on = 1'b0;
    wait_cyc(400); force_off_n = 1'b1;
    wait_cyc(455); tx_lines[1] = 1'b0;
    // R7 release with force-on high wakes at once
    expect_at(483, MAN, "R8");
    expect_at(503, WAKE_R, "R7");
    expect_at(510, WAKE_R, "R7");
    expect_at(511, UP, "R7");
    expect_at(530, UP, "R6");
    wait_cyc(480); force_off_n = 1'b0;
    wait_cyc(490); force_on = 1'b1;
    wait_cyc(500); force_off_n = 1'b1;
    wait_cyc(520); force_on = 1'b0;
    wait_cyc(535);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending expectations: got %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule